// File: doc/BRIEF.md
# Descriptor-Chained Buffer DMA Sequencer

This block is one transfer channel of a host-memory DMA engine. Samples arrive on a push port into a local FIFO. The sequencer drains the FIFO into host memory, one 32-bit write request per sample. It walks a small table of buffer descriptors, and each descriptor gives a base address, a size in samples and a set of control flags. The block keeps the index of the buffer in use and an offset counter inside that buffer. For each write it forms the address as base plus four times the offset. When a buffer fills, the block moves to the next descriptor, loops back to the first, or stops, as the flags of the filled descriptor direct.

Software controls the channel through an action register. It writes Clear, Start or Pause there, then polls a mirrored last-action readback until that readback shows the value it wrote. The engine updates the readback only when the action has taken effect, so an action stays pending while a host write is outstanding. Four status bytes record events: buffer completion, an invalid descriptor, a FIFO overflow and a stray grant. Each status byte is cleared by writing zero to it. A level interrupt request combines the per-buffer completion interrupt with the error flags, and an enable bit gates the error flags.

Top module: `seqdma_top`

## Requirements
- R1: Writing action 0x00 (Clear) stops the transfer, and once it is applied the current-buffer index, the offset and the FIFO level all read 0.
- R2: Action codes are 0x00 Clear, 0x01 Start and 0x02 Pause. A write at clock edge E shows up on the last-action readback from edge E+1 if no host request is outstanding. If a request is outstanding, the readback changes one edge after that request is granted. Until then the readback keeps its old value. A stop that the hardware causes itself sets the readback to 0x02.
- R3: While the channel is running, samples leave the FIFO in arrival order. Each sample goes to the address base + 4*offset of the current descriptor, and the offset steps by one on each grant.
- R4: The grant that brings the offset up to the buffer size resets the offset to 0 and sets bit 0 of status byte 0. It also advances the index by one, and after the last descriptor the index wraps to 0.
- R5: Descriptor flag bit 2 (loop) sends the index to 0 when the buffer fills, and the channel keeps running. Loop takes priority over flag bit 1 (halt).
- R6: Flag bit 1 (halt) without loop advances the index when the buffer fills and then pauses the channel, so the last-action readback shows 0x02.
- R7: If flag bit 0 (valid) is clear on the descriptor about to be used, then while the channel is running with no request outstanding, the channel sets bit 0 of status byte 1, pauses, and issues no request.
- R8: If flag bit 3 (interrupt) is set on a buffer when it fills, bit 1 of status byte 0 is set. irq is high while that bit is set, or while bit 0 of the control register is 1 and any of status bytes 1 to 3 is nonzero.
- R9: A push into a FIFO that already holds FIFO_DEPTH samples, in a cycle with no pop, drops the sample and sets bit 0 of status byte 2 whatever the error enable is. If the channel was running, it pauses.
- R10: A grant that arrives while no request is outstanding sets bit 0 of status byte 3.
- R11: The status register holds four bytes: completion in byte 0, invalid descriptor in byte 1, overflow in byte 2 and stray grant in byte 3. A write whose byte enable selects a byte and whose data for that byte is 0x00 clears that byte. A nonzero data byte leaves the byte unchanged.
- R12: memReq stays high with memAddr and memData stable until the cycle in which memGnt is high, and it drops at the next edge. Each sample is written exactly once.
- R13: The register map is as follows. Address 0 is the action register on write and the last-action readback on read. Address 1 is status, 2 is control, 3 is the current-buffer index and 4 is the offset. Address 5 is the read-only descriptor count (N_DESC), and 6 is the FIFO level. Descriptor i occupies addresses 8+4*i, 8+4*i+1 and 8+4*i+2, which hold its base address, its size and its flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | RA_W | Register word address |
| regByteEn | input | 4 | Byte enables for register writes |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| pushValid | input | 1 | Sample push into the channel FIFO |
| pushData | input | 32 | Sample being pushed |
| memReq | output | 1 | Host write request |
| memGnt | input | 1 | Host accepts the request in this cycle |
| memAddr | output | ADDR_W | Host write byte address |
| memData | output | 32 | Host write data |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with four descriptors, an 8-bit size field and a FIFO depth of 7. With these values a burst of seven samples crosses three buffer boundaries, and nine back-to-back pushes against a stalled grant reach the full FIFO and exactly one overflow. The small descriptor table makes the index wrap after the last entry easy to observe, and the bench also checks that loop wins over halt when both are set. The expected host addresses and data for every write are worked out arithmetically from the descriptor bases and sizes. The bench holds off grants so that it can see an action stay pending behind an outstanding request.

// File: rtl/seqdma_pkg.sv
package seqdma_pkg;
  localparam int SAMPLE_W = 32;

  localparam logic [7:0] ACT_CLEAR = 8'h00;
  localparam logic [7:0] ACT_START = 8'h01;
  localparam logic [7:0] ACT_PAUSE = 8'h02;

  localparam int REG_ACTION  = 0;
  localparam int REG_STATUS  = 1;
  localparam int REG_CONTROL = 2;
  localparam int REG_CURIDX  = 3;
  localparam int REG_OFFSET  = 4;
  localparam int REG_NDESC   = 5;
  localparam int REG_LEVEL   = 6;
  localparam int DESC_BASE   = 8;
  localparam int DESC_STRIDE = 4;

  localparam int FLAG_VALID = 0;
  localparam int FLAG_HALT  = 1;
  localparam int FLAG_LOOP  = 2;
  localparam int FLAG_INTR  = 3;

  typedef struct packed {
    logic issue;
    logic fifoClear;
  } strobe_t;
endpackage

// File: rtl/seqdma_ctrl.sv
module seqdma_ctrl
  import seqdma_pkg::*;
#(
  parameter int N_DESC = 4,
  parameter int SIZE_W = 16,
  parameter int RA_W   = 5,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [3:0]        regByteEn,
  input  logic [31:0]       regWrData,
  input  logic              pushValid,
  input  logic              memReq,
  input  logic              memGnt,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  input  logic [SIZE_W-1:0] descSize,
  input  logic [3:0]        descFlags,
  input  logic              errIntEn,
  output strobe_t           strb,
  output logic [7:0]        lastAction,
  output logic [IDX_W-1:0]  curIdx,
  output logic [SIZE_W-1:0] offset,
  output logic [31:0]       status,
  output logic              irq
);
  logic       pendValid;
  logic [7:0] pendAct;
  logic       running, applyNow, grantNow, lastWord;
  logic       invEvt, ovfEvt, unfEvt, actWr, statWr;
  logic [3:0] statClr;
  logic       cmpDone, cmpIrq, stInv, stOvf, stUnf;

  assign running  = (lastAction == ACT_START);
  assign applyNow = pendValid && !memReq;
  assign grantNow = memReq && memGnt;
  assign lastWord = ({1'b0, offset} + (SIZE_W+1)'(1)) >= {1'b0, descSize};

  assign invEvt = running && !applyNow && !memReq && !descFlags[FLAG_VALID];
  assign strb.issue = running && !applyNow && !memReq &&
                      descFlags[FLAG_VALID] && !fifoEmpty;
  assign strb.fifoClear = applyNow && (pendAct == ACT_CLEAR);
  assign ovfEvt = pushValid && fifoFull && !strb.issue;
  assign unfEvt = memGnt && !memReq;

  assign actWr  = regWrEn && (regAddr == RA_W'(REG_ACTION)) && regByteEn[0] &&
                  (regWrData[7:0] <= ACT_PAUSE);
  assign statWr = regWrEn && (regAddr == RA_W'(REG_STATUS));

  for (genvar b = 0; b < 4; b++) begin : g_clr
    assign statClr[b] = statWr && regByteEn[b] && (regWrData[8*b +: 8] == 8'h00);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAct   <= ACT_CLEAR;
    end else if (actWr) begin
      pendValid <= 1'b1;
      pendAct   <= regWrData[7:0];
    end else if (applyNow) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastAction <= ACT_CLEAR;
      curIdx     <= '0;
      offset     <= '0;
    end else if (applyNow) begin
      lastAction <= pendAct;
      if (pendAct == ACT_CLEAR) begin
        curIdx <= '0;
        offset <= '0;
      end
    end else begin
      if (grantNow) begin
        if (lastWord) begin
          offset <= '0;
          if (descFlags[FLAG_LOOP]) begin
            curIdx <= '0;
          end else begin
            curIdx <= (curIdx == IDX_W'(N_DESC-1)) ? '0 : curIdx + 1'b1;
            if (descFlags[FLAG_HALT]) lastAction <= ACT_PAUSE;
          end
        end else begin
          offset <= offset + 1'b1;
        end
      end
      if (invEvt || (ovfEvt && running)) lastAction <= ACT_PAUSE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpDone <= 1'b0;
      cmpIrq  <= 1'b0;
      stInv   <= 1'b0;
      stOvf   <= 1'b0;
      stUnf   <= 1'b0;
    end else begin
      if (grantNow && lastWord) cmpDone <= 1'b1;
      else if (statClr[0])      cmpDone <= 1'b0;
      if (grantNow && lastWord && descFlags[FLAG_INTR]) cmpIrq <= 1'b1;
      else if (statClr[0])                              cmpIrq <= 1'b0;
      if (invEvt)          stInv <= 1'b1;
      else if (statClr[1]) stInv <= 1'b0;
      if (ovfEvt)          stOvf <= 1'b1;
      else if (statClr[2]) stOvf <= 1'b0;
      if (unfEvt)          stUnf <= 1'b1;
      else if (statClr[3]) stUnf <= 1'b0;
    end
  end

  assign status = {7'b0, stUnf, 7'b0, stOvf, 7'b0, stInv, 6'b0, cmpIrq, cmpDone};
  assign irq    = cmpIrq | (errIntEn & (stInv | stOvf | stUnf));
endmodule

// File: rtl/seqdma_dpath.sv
module seqdma_dpath
  import seqdma_pkg::*;
#(
  parameter int N_DESC     = 4,
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 16,
  parameter int FIFO_DEPTH = 511,
  parameter int RA_W       = 5,
  parameter int IDX_W      = 2,
  parameter int PTR_W      = 9,
  parameter int LVL_W      = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [RA_W-1:0]     regAddr,
  input  logic [3:0]          regByteEn,
  input  logic [31:0]         regWrData,
  input  logic                pushValid,
  input  logic [SAMPLE_W-1:0] pushData,
  input  strobe_t             strb,
  input  logic [IDX_W-1:0]    curIdx,
  input  logic [SIZE_W-1:0]   offset,
  input  logic                memGnt,
  input  logic [7:0]          lastAction,
  input  logic [31:0]         status,
  output logic                memReq,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [SAMPLE_W-1:0] memData,
  output logic                fifoFull,
  output logic                fifoEmpty,
  output logic [SIZE_W-1:0]   descSize,
  output logic [3:0]          descFlags,
  output logic                errIntEn,
  output logic [31:0]         regRdData
);
  logic [31:0] descA [N_DESC];
  logic [31:0] descS [N_DESC];
  logic [31:0] descF [N_DESC];

  function automatic logic [31:0] mergeBytes(input logic [31:0] o, input logic [31:0] n,
                                             input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  for (genvar i = 0; i < N_DESC; i++) begin : g_desc
    always_ff @(posedge clk) begin
      if (!rstN) begin
        descA[i] <= '0;
        descS[i] <= '0;
        descF[i] <= '0;
      end else if (regWrEn) begin
        if (regAddr == RA_W'(DESC_BASE + DESC_STRIDE*i))
          descA[i] <= mergeBytes(descA[i], regWrData, regByteEn);
        if (regAddr == RA_W'(DESC_BASE + DESC_STRIDE*i + 1))
          descS[i] <= mergeBytes(descS[i], regWrData, regByteEn);
        if (regAddr == RA_W'(DESC_BASE + DESC_STRIDE*i + 2))
          descF[i] <= mergeBytes(descF[i], regWrData, regByteEn);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errIntEn <= 1'b0;
    else if (regWrEn && regAddr == RA_W'(REG_CONTROL) && regByteEn[0]) errIntEn <= regWrData[0];
  end

  assign descSize  = descS[curIdx][SIZE_W-1:0];
  assign descFlags = descF[curIdx][3:0];

  logic [SAMPLE_W-1:0] fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]    wrPtr, rdPtr;
  logic [LVL_W-1:0]    level;
  logic                pushOk, pop;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign pop       = strb.issue;
  assign fifoFull  = (level == LVL_W'(FIFO_DEPTH));
  assign fifoEmpty = (level == '0);
  assign pushOk    = pushValid && (!fifoFull || pop);

  always_ff @(posedge clk) begin
    if (!rstN || strb.fifoClear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (pushOk) wrPtr <= stepPtr(wrPtr);
      if (pop)    rdPtr <= stepPtr(rdPtr);
      if (pushOk && !pop)      level <= level + 1'b1;
      else if (pop && !pushOk) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk && !strb.fifoClear) fifoMem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReq  <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else if (strb.issue) begin
      memReq  <= 1'b1;
      memAddr <= descA[curIdx][ADDR_W-1:0] + ADDR_W'({offset, 2'b00});
      memData <= fifoMem[rdPtr];
    end else if (memGnt) begin
      memReq <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      RA_W'(REG_ACTION):  regRdData = 32'(lastAction);
      RA_W'(REG_STATUS):  regRdData = status;
      RA_W'(REG_CONTROL): regRdData = 32'(errIntEn);
      RA_W'(REG_CURIDX):  regRdData = 32'(curIdx);
      RA_W'(REG_OFFSET):  regRdData = 32'(offset);
      RA_W'(REG_NDESC):   regRdData = 32'(N_DESC);
      RA_W'(REG_LEVEL):   regRdData = 32'(level);
      default:            regRdData = '0;
    endcase
    for (int i = 0; i < N_DESC; i++) begin
      if (regAddr == RA_W'(DESC_BASE + DESC_STRIDE*i))     regRdData = descA[i];
      if (regAddr == RA_W'(DESC_BASE + DESC_STRIDE*i + 1)) regRdData = descS[i];
      if (regAddr == RA_W'(DESC_BASE + DESC_STRIDE*i + 2)) regRdData = descF[i];
    end
  end
endmodule

// File: rtl/seqdma_top.sv
module seqdma_top
  import seqdma_pkg::*;
#(
  parameter int N_DESC     = 4,
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 16,
  parameter int FIFO_DEPTH = 511,
  localparam int IDX_W     = (N_DESC > 1) ? $clog2(N_DESC) : 1,
  localparam int RA_W      = $clog2(DESC_BASE + DESC_STRIDE*N_DESC),
  localparam int PTR_W     = $clog2(FIFO_DEPTH),
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [RA_W-1:0]     regAddr,
  input  logic [3:0]          regByteEn,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  input  logic                pushValid,
  input  logic [SAMPLE_W-1:0] pushData,
  output logic                memReq,
  input  logic                memGnt,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [SAMPLE_W-1:0] memData,
  output logic                irq
);
  strobe_t           strb;
  logic [7:0]        lastAction;
  logic [IDX_W-1:0]  curIdx;
  logic [SIZE_W-1:0] offset;
  logic [31:0]       status;
  logic              fifoFull, fifoEmpty, errIntEn;
  logic [SIZE_W-1:0] descSize;
  logic [3:0]        descFlags;

  seqdma_ctrl #(.N_DESC(N_DESC), .SIZE_W(SIZE_W), .RA_W(RA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regByteEn(regByteEn), .regWrData(regWrData), .pushValid(pushValid),
    .memReq(memReq), .memGnt(memGnt), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .descSize(descSize), .descFlags(descFlags), .errIntEn(errIntEn),
    .strb(strb), .lastAction(lastAction), .curIdx(curIdx), .offset(offset),
    .status(status), .irq(irq)
  );

  seqdma_dpath #(.N_DESC(N_DESC), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
                 .FIFO_DEPTH(FIFO_DEPTH), .RA_W(RA_W), .IDX_W(IDX_W),
                 .PTR_W(PTR_W), .LVL_W(LVL_W)) u_dpath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regByteEn(regByteEn), .regWrData(regWrData), .pushValid(pushValid),
    .pushData(pushData), .strb(strb), .curIdx(curIdx), .offset(offset),
    .memGnt(memGnt), .lastAction(lastAction), .status(status),
    .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .descSize(descSize),
    .descFlags(descFlags), .errIntEn(errIntEn), .regRdData(regRdData)
  );
endmodule

// File: rtl/seqdma_chk.sv
module seqdma_chk
  import seqdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2,
  parameter int SIZE_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                pushValid,
  input logic                memReq,
  input logic                memGnt,
  input logic [ADDR_W-1:0]   memAddr,
  input logic [SAMPLE_W-1:0] memData,
  input logic                fifoFull,
  input strobe_t             strb,
  input logic [7:0]          lastAction,
  input logic [IDX_W-1:0]    curIdx,
  input logic [SIZE_W-1:0]   offset,
  input logic [31:0]         status
);
  // R12: request holds until granted
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr) && $stable(memData));

  // R12: request drops after its grant
  a_r12_req_drop: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memGnt && !strb.issue |=> !memReq);

  // R1: a cleared channel sits at index 0, offset 0
  a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    lastAction == ACT_CLEAR |-> curIdx == '0 && offset == '0);

  // R2: requests are only issued by a running channel
  a_r2_issue_running: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> lastAction == ACT_START && !memReq);

  // R9: overflow always sets its flag
  a_r9_overflow_flag: assert property (@(posedge clk) disable iff (!rstN)
    pushValid && fifoFull && !strb.issue |=> status[16]);

  // R10: stray grant sets its flag
  a_r10_stray_grant: assert property (@(posedge clk) disable iff (!rstN)
    memGnt && !memReq |=> status[24]);
endmodule

bind seqdma_top seqdma_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .memReq(memReq), .memGnt(memGnt),
  .memAddr(memAddr), .memData(memData), .fifoFull(fifoFull), .strb(strb),
  .lastAction(lastAction), .curIdx(curIdx), .offset(offset), .status(status)
);

// File: tb/seqdma_top_tb.sv
module seqdma_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NDESC = 4;
  localparam int DEPTH = 7;
  localparam logic [4:0] A_ACT = 0, A_STAT = 1, A_CTL = 2, A_IDX = 3, A_OFF = 4,
                         A_NDESC = 5, A_LVL = 6;

  logic clk = 0, rstN = 0;
  logic regWrEn = 0;
  logic [4:0] regAddr = 0;
  logic [3:0] regByteEn = 0;
  logic [31:0] regWrData = 0, regRdData;
  logic pushValid = 0;
  logic [31:0] pushData = 0;
  logic memReq, memGnt = 0, irq;
  logic [31:0] memAddr, memData;

  int nChecks = 0, nFail = 0, nLog = 0;
  bit done = 0, autoGnt = 1, manualGnt = 0;
  logic [31:0] logAddr [64];
  logic [31:0] logData [64];
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  seqdma_top #(.N_DESC(NDESC), .ADDR_W(32), .SIZE_W(8), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regByteEn(regByteEn), .regWrData(regWrData), .regRdData(regRdData),
    .pushValid(pushValid), .pushData(pushData), .memReq(memReq), .memGnt(memGnt),
    .memAddr(memAddr), .memData(memData), .irq(irq)
  );

  always @(negedge clk) begin
    if (autoGnt) memGnt = memReq;
    else memGnt = manualGnt;
    if (memGnt && memReq && nLog < 64) begin
      logAddr[nLog] = memAddr;
      logData[nLog] = memData;
      nLog++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d; regByteEn = be;
    @(posedge clk); #1;
    regWrEn = 0;
  endtask

  task automatic regRd(input logic [4:0] a, output logic [31:0] d);
    regAddr = a; #1;
    d = regRdData;
  endtask

  task automatic rdChk(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    regRd(a, v);
    chk(req, v, exp);
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    pushValid = 1; pushData = d;
    @(posedge clk); #1;
    pushValid = 0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setDesc(input int i, input logic [31:0] base, input logic [31:0] sz,
                         input logic [31:0] fl);
    regWr(5'(8 + 4*i), base, 4'hF);
    regWr(5'(8 + 4*i + 1), sz, 4'hF);
    regWr(5'(8 + 4*i + 2), fl, 4'hF);
  endtask

  // Expected order of writes through d0 (3), d1 (2), d2 (2)
  task automatic chkRun(input int first, input logic [31:0] dbase);
    int sz [3];
    int k;
    sz[0] = 3; sz[1] = 2; sz[2] = 2;
    k = 0;
    for (int d = 0; d < 3; d++) begin
      for (int j = 0; j < sz[d]; j++) begin
        chk("R3 address", logAddr[first+k], 32'h1000*(d+1) + 4*j);
        chk("R3 data", logData[first+k], dbase + k);
        k++;
      end
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    #1;
    // reset state, R13 map
    rdChk("R13 reset lastAction", A_ACT, 0);
    rdChk("R13 reset index", A_IDX, 0);
    rdChk("R13 reset offset", A_OFF, 0);
    rdChk("R13 descriptor count", A_NDESC, NDESC);
    rdChk("R13 reset level", A_LVL, 0);
    rdChk("R13 reset status", A_STAT, 0);
    chk("R12 reset memReq", {31'b0, memReq}, 0);
    chk("R8 reset irq", {31'b0, irq}, 0);

    setDesc(0, 32'h1000, 3, 32'h1);
    setDesc(1, 32'h2000, 2, 32'h9);
    setDesc(2, 32'h3000, 2, 32'h7);
    setDesc(3, 32'h4000, 1, 32'h1);
    rdChk("R13 descriptor size readback", 5'(8+4+1), 2);

    // R2: acknowledge timing with nothing outstanding
    regWr(A_ACT, 32'h1, 4'h1);
    rdChk("R2 lastAction before apply", A_ACT, 0);
    waitCyc(1);
    rdChk("R2 lastAction after apply", A_ACT, 1);

    // run 1: loop beats halt on d2
    for (int k = 0; k < 7; k++) push(32'hA000 + k);
    waitCyc(40);
    chk("R12 write count run1", nLog, 7);
    chkRun(0, 32'hA000);
    rdChk("R5 loop index back to 0", A_IDX, 0);
    rdChk("R4 offset reset", A_OFF, 0);
    rdChk("R5 still running", A_ACT, 1);
    rdChk("R4 R8 complete and irq bits", A_STAT, 32'h3);
    chk("R8 irq from buffer interrupt", {31'b0, irq}, 1);
    regWr(A_STAT, 32'h0, 4'h1);
    rdChk("R11 byte0 cleared", A_STAT, 0);
    chk("R8 irq cleared", {31'b0, irq}, 0);

    // run 2: halt alone on d2
    regWr(5'(8+8+2), 32'h3, 4'hF);
    regWr(A_ACT, 32'h1, 4'h1);
    for (int k = 0; k < 7; k++) push(32'hB000 + k);
    waitCyc(40);
    chk("R12 write count run2", nLog, 14);
    chkRun(7, 32'hB000);
    rdChk("R6 halt advances index", A_IDX, 3);
    rdChk("R6 halt pauses", A_ACT, 2);
    regWr(A_STAT, 32'hFF, 4'h1);
    rdChk("R11 nonzero write keeps byte", A_STAT, 32'h3);
    regWr(A_STAT, 32'h0, 4'h1);

    // R7: invalid descriptor 3
    regWr(5'(8+12+2), 32'h0, 4'hF);
    push(32'hC000);
    regWr(A_ACT, 32'h1, 4'h1);
    waitCyc(10);
    rdChk("R7 invalid flag", A_STAT, 32'h100);
    rdChk("R7 paused", A_ACT, 2);
    chk("R7 no request issued", nLog, 14);
    rdChk("R7 sample kept", A_LVL, 1);
    chk("R8 error irq disabled", {31'b0, irq}, 0);
    regWr(A_CTL, 32'h1, 4'h1);
    chk("R8 error irq enabled", {31'b0, irq}, 1);
    regWr(A_CTL, 32'h0, 4'h1);

    // R4: wrap after last descriptor without loop
    regWr(5'(8+12+2), 32'h1, 4'hF);
    regWr(A_STAT, 32'h0, 4'h2);
    regWr(A_ACT, 32'h1, 4'h1);
    waitCyc(10);
    chk("R3 d3 address", logAddr[14], 32'h4000);
    chk("R3 d3 data", logData[14], 32'hC000);
    rdChk("R4 index wraps to 0", A_IDX, 0);
    rdChk("R4 complete only", A_STAT, 32'h1);
    regWr(A_STAT, 32'h0, 4'h1);

    // R9: overflow with grants held off
    autoGnt = 0;
    for (int k = 0; k < 9; k++) push(32'hD000 + k);
    #1;
    rdChk("R9 overflow flag", A_STAT, 32'h10000);
    rdChk("R9 paused on overflow", A_ACT, 2);
    rdChk("R9 level full", A_LVL, DEPTH);
    waitCyc(3);
    chk("R12 request held", {31'b0, memReq}, 1);
    chk("R12 address held", memAddr, 32'h1000);
    chk("R12 data held", memData, 32'hD000);
    regWr(A_ACT, 32'h0, 4'h1);
    waitCyc(3);
    rdChk("R2 action deferred behind request", A_ACT, 2);
    autoGnt = 1;
    waitCyc(6);
    chk("R12 write count after release", nLog, 16);
    chk("R12 released address", logAddr[15], 32'h1000);
    rdChk("R2 Clear applied after grant", A_ACT, 0);
    rdChk("R1 FIFO emptied", A_LVL, 0);
    rdChk("R1 offset reset", A_OFF, 0);
    rdChk("R1 index reset", A_IDX, 0);
    regWr(A_STAT, 32'h0, 4'h4);

    // R10: stray grant
    autoGnt = 0;
    manualGnt = 1;
    waitCyc(1);
    manualGnt = 0;
    waitCyc(2);
    rdChk("R10 stray grant flag", A_STAT, 32'h01000000);
    regWr(A_STAT, 32'h0, 4'h8);
    rdChk("R11 byte3 cleared", A_STAT, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule